// File: doc/BRIEF.md
# Interrupt Message Decoder

This block turns the single-cycle interrupt messages sent by on-chip devices into held level signals. A device sends one message when its interrupt line goes active and another when it goes inactive. The decoder keeps the current level of every line in a register until the opposite message arrives.

Each message carries a kind bit, a device number, a two-bit selector and a polarity flag. Messages of the PCI kind update one pin (A to D) of one device in a per-device, per-pin level array, which goes to the interrupt router. Messages of the legacy kind update one of four legacy IRQ lines, which go to the 8259-style controller. Both groups are updated one clock after the message is accepted. A message that repeats the current state of a line is harmless.

Top module: `irq_msg_decoder`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every bit of `intx_level` and `legacy_irq` at that edge, even when a message is presented in the same cycle.
- R2: An accepted message with `msg_type` = 0 and `msg_assert` = 1 sets bit `intx_level[msg_dev*4 + msg_sel]`, where `msg_sel` 0..3 means pin A..D. The bit is visible after the rising edge at which the message was sampled.
- R3: An accepted message with `msg_type` = 0 and `msg_assert` = 0 clears bit `intx_level[msg_dev*4 + msg_sel]` at the same edge timing as R2.
- R4: An accepted message changes exactly the one line it addresses. Every other bit of `intx_level` and `legacy_irq` keeps its value.
- R5: An accepted message with `msg_type` = 1 sets (`msg_assert` = 1) or clears (`msg_assert` = 0) bit `legacy_irq[msg_sel]`. Bits 0, 1, 2 and 3 stand for IRQ3, IRQ4, IRQ14 and IRQ15. `msg_dev` plays no part in a legacy message.
- R6: A legacy message leaves `intx_level` unchanged, and a PCI message leaves `legacy_irq` unchanged.
- R7: An assert to a line that is already set, or a deassert to a line that is already clear, leaves all outputs unchanged.
- R8: While `msg_valid` is low, no output changes, whatever the other message fields carry.
- R9: A level, once set or cleared, holds over any number of idle cycles until a message of the opposite polarity for the same line arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_valid | input | 1 | Message present in this cycle |
| msg_type | input | 1 | 0 = PCI pin message, 1 = legacy IRQ message |
| msg_dev | input | DEV_W (5) | Sending device number (PCI messages only) |
| msg_sel | input | SEL_W (2) | Pin A..D, or legacy line index |
| msg_assert | input | 1 | 1 = line goes active, 0 = line goes inactive |
| intx_level | output | NUM_DEV*NUM_PIN (128) | Held level per device pin, bit dev*4+pin |
| legacy_irq | output | NUM_LEG (4) | Held levels of IRQ3, IRQ4, IRQ14, IRQ15 |

## Verification
Two things can happen in the same cycle: a synchronous reset and an accepted message. The bench presents a valid assert message while `rst_n` is low. It requires the outputs to be all zero after that edge, so the reset wins and the message is lost. The bench also compares its behavioural level model against both output groups on every clock. This covers long random runs in which set, clear, redundant and idle cycles follow each other back to back on the same and on different lines.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

   // Kind of an incoming interrupt message
   typedef enum logic {
      MSG_PCI_PIN = 1'b0,
      MSG_LEGACY  = 1'b1
   } msg_kind_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int width_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_msg_field_decode.sv
// Turns one message into one-hot set / clear strobes for both level groups.
module irq_msg_field_decode
   import irq_msg_pkg::*;
#(
   parameter int NUM_DEV = 32,
   parameter int NUM_PIN = 4,
   parameter int NUM_LEG = 4,
   parameter int DEV_W   = 5,
   parameter int SEL_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       msg_valid,
   input  msg_kind_e                  msg_kind,
   input  logic [DEV_W-1:0]           msg_dev,
   input  logic [SEL_W-1:0]           msg_sel,
   input  logic                       msg_assert,
   output logic [NUM_DEV*NUM_PIN-1:0] pin_set,
   output logic [NUM_DEV*NUM_PIN-1:0] pin_clr,
   output logic [NUM_LEG-1:0]         leg_set,
   output logic [NUM_LEG-1:0]         leg_clr
);

   logic pci_go;
   logic leg_go;

   assign pci_go = msg_valid && (msg_kind == MSG_PCI_PIN);
   assign leg_go = msg_valid && (msg_kind == MSG_LEGACY);

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
         logic hit;
         assign hit = pci_go && (msg_dev == DEV_W'(d)) && (msg_sel == SEL_W'(p));
         assign pin_set[d*NUM_PIN + p] = hit &&  msg_assert;
         assign pin_clr[d*NUM_PIN + p] = hit && !msg_assert;
      end
   end

   for (genvar l = 0; l < NUM_LEG; l++) begin : g_leg
      logic hit;
      assign hit = leg_go && (msg_sel == SEL_W'(l));
      assign leg_set[l] = hit &&  msg_assert;
      assign leg_clr[l] = hit && !msg_assert;
   end

   // R8
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |-> (pin_set == '0 && pin_clr == '0 && leg_set == '0 && leg_clr == '0));

   // R4
   single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pin_set, pin_clr, leg_set, leg_clr}));

endmodule

// File: rtl/irq_level_bank.sv
// Bank of held level bits, each set or cleared by a strobe.
module irq_level_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] level
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            level[i] <= 1'b0;
         else if (set_vec[i])
            level[i] <= 1'b1;
         else if (clr_vec[i])
            level[i] <= 1'b0;
      end
   end

   // R2
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((level & $past(set_vec)) == $past(set_vec)));

   // R3
   clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((level & $past(clr_vec)) == '0));

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec | clr_vec) == '0) |=> $stable(level));

endmodule

// File: rtl/irq_msg_decoder.sv
// Interrupt message decoder: message strobes in, held levels out.
module irq_msg_decoder
   import irq_msg_pkg::*;
#(
   parameter  int NUM_DEV = 32,
   parameter  int NUM_PIN = 4,
   parameter  int NUM_LEG = 4,
   localparam int DEV_W   = width_for(NUM_DEV),
   localparam int SEL_W   = width_for(max_of(NUM_PIN, NUM_LEG))
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       msg_valid,
   input  logic                       msg_type,
   input  logic [DEV_W-1:0]           msg_dev,
   input  logic [SEL_W-1:0]           msg_sel,
   input  logic                       msg_assert,
   output logic [NUM_DEV*NUM_PIN-1:0] intx_level,
   output logic [NUM_LEG-1:0]         legacy_irq
);

   localparam int PIN_BITS = NUM_DEV * NUM_PIN;

   if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_dev
      $error("irq_msg_decoder: NUM_DEV out of range");
   end
   if (NUM_PIN < 1 || NUM_PIN > 4) begin : g_bad_pin
      $error("irq_msg_decoder: NUM_PIN must be 1..4");
   end
   if (NUM_LEG < 1 || NUM_LEG > 16) begin : g_bad_leg
      $error("irq_msg_decoder: NUM_LEG must be 1..16");
   end

   logic [PIN_BITS-1:0] pin_set;
   logic [PIN_BITS-1:0] pin_clr;
   logic [NUM_LEG-1:0]  leg_set;
   logic [NUM_LEG-1:0]  leg_clr;
   msg_kind_e           kind;

   assign kind = msg_kind_e'(msg_type);

   irq_msg_field_decode #(
      .NUM_DEV (NUM_DEV),
      .NUM_PIN (NUM_PIN),
      .NUM_LEG (NUM_LEG),
      .DEV_W   (DEV_W),
      .SEL_W   (SEL_W)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .msg_valid  (msg_valid),
      .msg_kind   (kind),
      .msg_dev    (msg_dev),
      .msg_sel    (msg_sel),
      .msg_assert (msg_assert),
      .pin_set    (pin_set),
      .pin_clr    (pin_clr),
      .leg_set    (leg_set),
      .leg_clr    (leg_clr)
   );

   irq_level_bank #(.WIDTH(PIN_BITS)) u_pin_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (pin_set),
      .clr_vec (pin_clr),
      .level   (intx_level)
   );

   irq_level_bank #(.WIDTH(NUM_LEG)) u_leg_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (leg_set),
      .clr_vec (leg_clr),
      .level   (legacy_irq)
   );

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (intx_level == '0 && legacy_irq == '0));

   // R6
   legacy_spares_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_type) |=> $stable(intx_level));

   // R6
   pci_spares_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_type) |=> $stable(legacy_irq));

   // R8
   idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> ($stable(intx_level) && $stable(legacy_irq)));

endmodule

// File: tb/tb_irq_msg_decoder.sv
`timescale 1ns/100ps
module tb_irq_msg_decoder;
   localparam int ND = 32;
   localparam int NP = 4;
   localparam int NL = 4;
   localparam int NB = ND * NP;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          msg_valid = 1'b0;
   logic          msg_type = 1'b0;
   logic [4:0]    msg_dev = '0;
   logic [1:0]    msg_sel = '0;
   logic          msg_assert = 1'b0;
   logic [NB-1:0] intx_level;
   logic [NL-1:0] legacy_irq;

   irq_msg_decoder #(.NUM_DEV(ND), .NUM_PIN(NP), .NUM_LEG(NL)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .msg_valid  (msg_valid),
      .msg_type   (msg_type),
      .msg_dev    (msg_dev),
      .msg_sel    (msg_sel),
      .msg_assert (msg_assert),
      .intx_level (intx_level),
      .legacy_irq (legacy_irq)
   );

   // Behavioural reference model
   logic [NB-1:0] m_pin = '0;
   logic [NL-1:0] m_leg = '0;
   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   bit    live = 1'b0;
   string req = "R1";

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_pin <= '0;
         m_leg <= '0;
      end else if (msg_valid) begin
         if (msg_type == 1'b0)
            m_pin[int'(msg_dev) * NP + int'(msg_sel)] <= msg_assert;
         else
            m_leg[int'(msg_sel)] <= msg_assert;
      end
   end

   task automatic check(input string r, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (live) begin
         check({req, " pin levels"}, intx_level, m_pin);
         check({req, " legacy levels"}, NB'(legacy_irq), NB'(m_leg));
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc > 60000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic send(input logic kind, input int dev, input int sel, input logic as);
      @(negedge clk);
      msg_valid  = 1'b1;
      msg_type   = kind;
      msg_dev    = 5'(dev);
      msg_sel    = 2'(sel);
      msg_assert = as;
      @(negedge clk);
      msg_valid  = 1'b0;
   endtask

   function automatic logic [NB-1:0] bitat(input int idx);
      logic [NB-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

   initial begin
      logic [NB-1:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live  = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 reset pins", intx_level, '0);
      check("R1 reset legacy", NB'(legacy_irq), '0);

      // R2 / R4: single assert, device 5 pin C
      req = "R2";
      send(1'b0, 5, 2, 1'b1);
      check("R2 set dev5 pinC", intx_level, bitat(22));
      check("R4 legacy untouched", NB'(legacy_irq), '0);

      // R7: repeated assert
      req = "R7";
      send(1'b0, 5, 2, 1'b1);
      check("R7 repeat assert", intx_level, bitat(22));

      // R2 boundaries: last and first line
      req = "R2";
      send(1'b0, 31, 3, 1'b1);
      send(1'b0, 0, 0, 1'b1);
      check("R2 edges", intx_level, bitat(22) | bitat(127) | bitat(0));

      // R3 clear, then R7 repeated clear
      req = "R3";
      send(1'b0, 5, 2, 1'b0);
      check("R3 clear dev5 pinC", intx_level, bitat(127) | bitat(0));
      req = "R7";
      send(1'b0, 5, 2, 1'b0);
      check("R7 repeat deassert", intx_level, bitat(127) | bitat(0));

      // R5 / R6: legacy lines IRQ3, IRQ4, IRQ14, IRQ15 with varying device field
      req = "R5";
      snap = intx_level;
      for (int s = 0; s < NL; s++) begin
         send(1'b1, 7 * s + 3, s, 1'b1);
         check("R5 legacy set", NB'(legacy_irq), NB'((1 << (s + 1)) - 1));
         check("R6 pins untouched", intx_level, snap);
      end
      send(1'b1, 0, 2, 1'b0);
      check("R5 clear IRQ14", NB'(legacy_irq), NB'(4'b1011));

      // R8 / R9: garbage fields with valid low, levels hold
      req = "R8";
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         msg_type   = 1'($urandom);
         msg_dev    = 5'($urandom);
         msg_sel    = 2'($urandom);
         msg_assert = 1'b1;
      end
      @(negedge clk);
      check("R9 pins held", intx_level, snap);
      check("R9 legacy held", NB'(legacy_irq), NB'(4'b1011));

      // R1: reset and a message in the same cycle, reset wins
      req = "R1";
      @(negedge clk);
      rst_n      = 1'b0;
      msg_valid  = 1'b1;
      msg_type   = 1'b0;
      msg_dev    = 5'd9;
      msg_sel    = 2'd1;
      msg_assert = 1'b1;
      @(negedge clk);
      msg_valid = 1'b0;
      rst_n     = 1'b1;
      check("R1 reset beats message pins", intx_level, '0);
      check("R1 reset beats message legacy", NB'(legacy_irq), '0);

      // R4 random traffic, compared every clock
      req = "R4";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         msg_valid  = ($urandom_range(0, 3) != 0);
         msg_type   = ($urandom_range(0, 4) == 0);
         msg_dev    = ($urandom_range(0, 1) != 0) ? 5'($urandom_range(0, 3)) : 5'($urandom);
         msg_sel    = 2'($urandom);
         msg_assert = 1'($urandom);
      end
      @(negedge clk);
      msg_valid = 1'b0;
      repeat (2) @(negedge clk);
      live = 1'b0;
      finish_run();
   end
endmodule